// File: doc/BRIEF.md
# Slave-Port Arbiter with Parking

This block is the arbitration and idle-control logic of one slave port in a bus crossbar with several masters. Each cycle it sees which masters want the port (`mst_req`) and which masters present an IDLE transfer to it (`mst_idle`). It holds a registered grant that names one master, and it tells the slave bus whether a real transfer is in progress (`slv_active`). When no master wants the port, the slave bus sees only IDLE cycles, even though a master may still be named in the grant. IDLE transfers from masters are completed by the block itself and never reach the slave.

The port's behaviour is set by a small control register, written through `cfg_wr`. It holds four things. The first is the arbitration mode: fixed priority, or round robin. The second is one priority level for each master. The third is the master to park on. The fourth is a low-power park flag. When the port idles at an arbitration point, it either parks the grant on the programmed master, or it drops the grant altogether. A parked master can start a transfer in the same cycle that it raises its request. After a low-power park, a requester pays one clock before it is granted. The grant moves only at arbitration points: when there is no grant, when the current owner stops requesting, or when `burst_end` signals the end of a transfer or a burst break.

Top module: `xbar_port_arb`

## Requirements
- R1: While `mst_req` is all zero, `slv_active` is low, even if `gnt_vld` is high.
- R2: For each master i, `mst_done[i]` is high in the same cycle whenever `mst_idle[i]` is high and `mst_req[i]` is low. The IDLE transfer does not raise `slv_active`.
- R3: With `cfg_park_lp`=0, an arbitration point with no requests leads on the next edge to `gnt_vld`=1 and `gnt_idx` equal to the stored park master. If that master then raises `mst_req`, `slv_active` is high in that same cycle.
- R4: With `cfg_park_lp`=1, an arbitration point with no requests clears `gnt_vld` on the next edge. A master that requests while `gnt_vld`=0 sees `slv_active` low in that cycle, and is granted on the following edge.
- R5: With `cfg_rr`=0 (fixed priority), the winner among the requesters is the master with the highest level. Master i's level is `cfg_prio[i*PRIO_W +: PRIO_W]`, and a larger value means higher priority. A tie goes to the lowest index.
- R6: With `cfg_rr`=1 (round robin), the search starts at the master after the last one granted to a request and wraps modulo N_MST. Parking does not move this starting point.
- R7: When `cfg_wr` is high at a rising edge, all four fields are captured at that edge. The new values govern the arbitration decision made in the next cycle, and none made earlier.
- R8: An arbitration point occurs when `gnt_vld` is 0, when the granted master is not requesting, or when `burst_end` is 1. In every other cycle, `gnt_vld` and `gnt_idx` keep their values.
- R9: `slv_active` equals `gnt_vld` AND `mst_req[gnt_idx]`. The owner's `mst_done` follows `slv_ready` while active. A requesting master that is not the owner sees `mst_done` low.
- R10: After reset, `gnt_vld`=0, `gnt_idx`=0 and `slv_active`=0. The configuration resets to park on master 0, fixed priority, and all levels 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | N_MST | Master i has a non-IDLE transfer for this port |
| mst_idle | input | N_MST | Master i presents an IDLE transfer to this port |
| burst_end | input | 1 | End of the owner's transfer, or a burst break |
| slv_ready | input | 1 | The slave completes the current beat |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_park_id | input | $clog2(N_MST) | Master to park on |
| cfg_park_lp | input | 1 | 1 = low-power park (no grant while idle) |
| cfg_rr | input | 1 | 1 = round robin, 0 = fixed priority |
| cfg_prio | input | N_MST*PRIO_W | Priority level for each master |
| gnt_vld | output | 1 | A master holds the grant |
| gnt_idx | output | $clog2(N_MST) | Index of the granted master |
| slv_active | output | 1 | Non-IDLE transfer driven on the slave bus |
| mst_done | output | N_MST | Transfer completion to each master |

## Verification
The assertions check on every cycle the rules that hold at any moment. They cover the forced idle on the slave bus with no requesters, the local completion of IDLE transfers, the hold of the grant between arbitration points, the park target, the low-power drop, and the capture of register writes at the edge. Only the bench's scenarios show the choice of winner. That covers priority ties going to the lower index, round-robin rotation past the last granted master, and the one-clock difference in first-transfer latency between parking on a master and low-power parking. A cycle-level reference model and directed sequences cover these cases.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    typedef enum logic {
        SEL_FIXED = 1'b0,
        SEL_ROUND = 1'b1
    } sel_mode_e;

    typedef enum logic [1:0] {
        NXT_HOLD  = 2'd0,
        NXT_GRANT = 2'd1,
        NXT_PARK  = 2'd2,
        NXT_SLEEP = 2'd3
    } nxt_kind_e;

    // index that lies 'step' places after 'base', wrapping at 'count'
    function automatic int wrap_add(input int base, input int step, input int count);
        return (base + step) % count;
    endfunction

endpackage

// File: rtl/xbar_port_cfg.sv
module xbar_port_cfg #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = $clog2(N_MST)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [IDX_W-1:0]          park_in,
    input  logic                      lp_in,
    input  logic                      rr_in,
    input  logic [N_MST*PRIO_W-1:0]   prio_in,
    output logic [IDX_W-1:0]          park_q,
    output logic                      lp_q,
    output xbar_arb_pkg::sel_mode_e   mode_q,
    output logic [N_MST*PRIO_W-1:0]   prio_q
);
    import xbar_arb_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            park_q <= '0;
            lp_q   <= 1'b0;
            mode_q <= SEL_FIXED;
            prio_q <= '0;
        end else if (wr) begin
            park_q <= park_in;
            lp_q   <= lp_in;
            mode_q <= rr_in ? SEL_ROUND : SEL_FIXED;
            prio_q <= prio_in;
        end
    end

endmodule

// File: rtl/xbar_port_pick.sv
module xbar_port_pick #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = $clog2(N_MST)
) (
    input  logic [N_MST-1:0]          req,
    input  xbar_arb_pkg::sel_mode_e   mode,
    input  logic [N_MST*PRIO_W-1:0]   prio,
    input  logic [IDX_W-1:0]          last,
    output logic                      any,
    output logic [IDX_W-1:0]          win
);
    import xbar_arb_pkg::*;

    logic [IDX_W-1:0]  fix_win;
    logic [PRIO_W-1:0] fix_lvl;
    logic              fix_hit;
    logic [IDX_W-1:0]  rot_win;
    logic              rot_hit;

    // fixed priority: strict greater-than keeps ties on the lower index
    always_comb begin
        fix_win = '0;
        fix_lvl = '0;
        fix_hit = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i] && (!fix_hit || prio[i*PRIO_W +: PRIO_W] > fix_lvl)) begin
                fix_hit = 1'b1;
                fix_win = IDX_W'(i);
                fix_lvl = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // round robin: scan starts one past the last winner
    always_comb begin
        rot_win = '0;
        rot_hit = 1'b0;
        for (int k = 1; k <= N_MST; k++) begin
            if (!rot_hit && req[wrap_add(int'(last), k, N_MST)]) begin
                rot_hit = 1'b1;
                rot_win = IDX_W'(wrap_add(int'(last), k, N_MST));
            end
        end
    end

    assign any = |req;
    assign win = (mode == SEL_ROUND) ? rot_win : fix_win;

endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = $clog2(N_MST)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_MST-1:0]          mst_req,
    input  logic [N_MST-1:0]          mst_idle,
    input  logic                      burst_end,
    input  logic                      slv_ready,
    input  logic                      cfg_wr,
    input  logic [IDX_W-1:0]          cfg_park_id,
    input  logic                      cfg_park_lp,
    input  logic                      cfg_rr,
    input  logic [N_MST*PRIO_W-1:0]   cfg_prio,
    output logic                      gnt_vld,
    output logic [IDX_W-1:0]          gnt_idx,
    output logic                      slv_active,
    output logic [N_MST-1:0]          mst_done
);
    import xbar_arb_pkg::*;

    logic [IDX_W-1:0]        park_q;
    logic                    lp_q;
    sel_mode_e               mode_q;
    logic [N_MST*PRIO_W-1:0] prio_q;
    logic [IDX_W-1:0]        last_q;
    logic                    any_req;
    logic [IDX_W-1:0]        pick_idx;
    logic                    arb_pt;
    nxt_kind_e               nxt;

    xbar_port_cfg #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .park_in (cfg_park_id),
        .lp_in   (cfg_park_lp),
        .rr_in   (cfg_rr),
        .prio_in (cfg_prio),
        .park_q  (park_q),
        .lp_q    (lp_q),
        .mode_q  (mode_q),
        .prio_q  (prio_q)
    );

    xbar_port_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .req  (mst_req),
        .mode (mode_q),
        .prio (prio_q),
        .last (last_q),
        .any  (any_req),
        .win  (pick_idx)
    );

    assign arb_pt     = !gnt_vld || !mst_req[gnt_idx] || burst_end;
    assign slv_active = gnt_vld && mst_req[gnt_idx];

    always_comb begin
        nxt = NXT_HOLD;
        if (arb_pt) begin
            if (any_req)   nxt = NXT_GRANT;
            else if (lp_q) nxt = NXT_SLEEP;
            else           nxt = NXT_PARK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_vld <= 1'b0;
            gnt_idx <= '0;
            last_q  <= IDX_W'(N_MST - 1);
        end else begin
            case (nxt)
                NXT_GRANT: begin
                    gnt_vld <= 1'b1;
                    gnt_idx <= pick_idx;
                    last_q  <= pick_idx;
                end
                NXT_PARK: begin
                    gnt_vld <= 1'b1;
                    gnt_idx <= park_q;
                end
                NXT_SLEEP: gnt_vld <= 1'b0;
                default:   ;
            endcase
        end
    end

    // IDLE transfers finish locally; real ones finish on the slave's ready
    generate
        for (genvar m = 0; m < N_MST; m++) begin : g_done
            assign mst_done[m] = (mst_idle[m] && !mst_req[m])
                               || (slv_active && gnt_idx == IDX_W'(m) && slv_ready);
        end
    endgenerate

endmodule

// File: rtl/xbar_port_arb_chk.sv
module xbar_port_arb_chk #(
    parameter int N_MST = 4,
    parameter int IDX_W = $clog2(N_MST)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_MST-1:0] mst_req,
    input logic [N_MST-1:0] mst_idle,
    input logic [N_MST-1:0] mst_done,
    input logic             burst_end,
    input logic             cfg_wr,
    input logic [IDX_W-1:0] cfg_park_id,
    input logic             cfg_park_lp,
    input logic             gnt_vld,
    input logic [IDX_W-1:0] gnt_idx,
    input logic             slv_active,
    input logic             arb_pt,
    input logic [IDX_W-1:0] park_q,
    input logic             lp_q
);

    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        (mst_req == '0) |-> !slv_active);

    a_r9_active_owner: assert property (@(posedge clk) disable iff (rst)
        slv_active |-> (gnt_vld && mst_req[gnt_idx]));

    a_r8_hold_grant: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && mst_req[gnt_idx] && !burst_end) |=> (gnt_vld && gnt_idx == $past(gnt_idx)));

    a_r3_park_target: assert property (@(posedge clk) disable iff (rst)
        (arb_pt && mst_req == '0 && !lp_q) |=> (gnt_vld && gnt_idx == $past(park_q)));

    a_r4_sleep_drop: assert property (@(posedge clk) disable iff (rst)
        (arb_pt && mst_req == '0 && lp_q) |=> !gnt_vld);

    a_r7_cfg_capture: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (park_q == $past(cfg_park_id) && lp_q == $past(cfg_park_lp)));

    generate
        for (genvar m = 0; m < N_MST; m++) begin : g_m
            a_r2_idle_local: assert property (@(posedge clk) disable iff (rst)
                (mst_idle[m] && !mst_req[m]) |-> mst_done[m]);
            a_r9_waiter_blocked: assert property (@(posedge clk) disable iff (rst)
                (mst_req[m] && !(gnt_vld && gnt_idx == IDX_W'(m))) |-> !mst_done[m]);
        end
    endgenerate

endmodule

bind xbar_port_arb xbar_port_arb_chk #(.N_MST(N_MST), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mst_req     (mst_req),
    .mst_idle    (mst_idle),
    .mst_done    (mst_done),
    .burst_end   (burst_end),
    .cfg_wr      (cfg_wr),
    .cfg_park_id (cfg_park_id),
    .cfg_park_lp (cfg_park_lp),
    .gnt_vld     (gnt_vld),
    .gnt_idx     (gnt_idx),
    .slv_active  (slv_active),
    .arb_pt      (arb_pt),
    .park_q      (park_q),
    .lp_q        (lp_q)
);

// File: tb/xbar_port_arb_bench.sv
`timescale 1ns/1ps
module xbar_port_arb_bench;
    localparam int N  = 4;
    localparam int PW = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic [N-1:0]    mst_req, mst_idle, mst_done;
    logic            burst_end, slv_ready, cfg_wr, cfg_park_lp, cfg_rr;
    logic [IW-1:0]   cfg_park_id, gnt_idx;
    logic [N*PW-1:0] cfg_prio;
    logic            gnt_vld, slv_active;

    xbar_port_arb #(.N_MST(N), .PRIO_W(PW)) u_xbar_port_arb (
        .clk(clk), .rst(rst), .mst_req(mst_req), .mst_idle(mst_idle),
        .burst_end(burst_end), .slv_ready(slv_ready), .cfg_wr(cfg_wr),
        .cfg_park_id(cfg_park_id), .cfg_park_lp(cfg_park_lp), .cfg_rr(cfg_rr),
        .cfg_prio(cfg_prio), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
        .slv_active(slv_active), .mst_done(mst_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    int m_vld, m_idx, m_last, m_park, m_lp, m_rr;
    logic [N*PW-1:0] m_prio;
    string m_why;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int lvl(input int i);
        return int'(m_prio[i*PW +: PW]);
    endfunction

    function automatic int ref_pick();
        int best = -1;
        if (m_rr != 0) begin
            for (int k = 1; k <= N; k++)
                if (best < 0 && mst_req[(m_last + k) % N]) best = (m_last + k) % N;
        end else begin
            for (int i = 0; i < N; i++)
                if (mst_req[i] && (best < 0 || lvl(i) > lvl(best))) best = i;
        end
        return best;
    endfunction

    task automatic compare();
        int exp_act;
        logic [N-1:0] exp_done;
        exp_act = (m_vld != 0 && mst_req[m_idx]) ? 1 : 0;
        for (int i = 0; i < N; i++)
            exp_done[i] = (mst_idle[i] && !mst_req[i]) || (exp_act != 0 && m_idx == i && slv_ready);
        check((mst_req == '0) ? "R1" : "R9", "slv_active", int'(slv_active), exp_act);
        check("R2", "mst_done", int'(mst_done), int'(exp_done));
        check(m_why, "gnt_vld", int'(gnt_vld), m_vld);
        check(m_why, "gnt_idx", int'(gnt_idx), m_idx);
    endtask

    task automatic model_step();
        int w;
        if (m_vld == 0 || !mst_req[m_idx] || burst_end) begin
            if (mst_req != '0) begin
                w = ref_pick();
                m_vld = 1; m_idx = w; m_last = w;
                m_why = (m_rr != 0) ? "R6" : "R5";
            end else if (m_lp != 0) begin
                m_vld = 0; m_why = "R4";
            end else begin
                m_vld = 1; m_idx = m_park; m_why = "R3";
            end
        end else begin
            m_why = "R8";
        end
        if (cfg_wr) begin
            m_park = int'(cfg_park_id); m_lp = int'(cfg_park_lp);
            m_rr = int'(cfg_rr); m_prio = cfg_prio;
        end
    endtask

    // inputs already driven at the falling edge
    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic drive(input logic [N-1:0] rq, input logic be);
        mst_req = rq; mst_idle = ~rq; burst_end = be; slv_ready = 1'b1; cfg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog R1..R10 run actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a1b));
        rst = 1'b1;
        drive('0, 1'b0);
        mst_idle = '0;
        cfg_park_id = '0; cfg_park_lp = 1'b0; cfg_rr = 1'b0; cfg_prio = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_vld = 0; m_idx = 0; m_last = N - 1; m_park = 0; m_lp = 0; m_rr = 0;
        m_prio = '0; m_why = "R10";

        // R10 reset state
        #1;
        check("R10", "gnt_vld", int'(gnt_vld), 0);
        check("R10", "gnt_idx", int'(gnt_idx), 0);
        check("R10", "slv_active", int'(slv_active), 0);
        cyc(); cyc();
        check("R3", "reset park on 0", int'({gnt_vld, gnt_idx}), 4);

        // R7: park field changes one decision later
        drive('0, 1'b0);
        cfg_wr = 1'b1; cfg_park_id = 2'd2; cfg_park_lp = 1'b0;
        cyc();
        cfg_wr = 1'b0;
        check("R7", "old park still used", int'(gnt_idx), 0);
        cyc();
        check("R7", "new park used", int'(gnt_idx), 2);

        // R3 zero-latency start for parked master
        drive(4'b0100, 1'b0);
        #1;
        check("R3", "parked start same cycle", int'(slv_active), 1);
        cyc();

        // R4 low-power park and one-clock penalty
        drive('0, 1'b0);
        cfg_wr = 1'b1; cfg_park_lp = 1'b1;
        cyc();
        cfg_wr = 1'b0;
        cyc();
        check("R4", "grant dropped", int'(gnt_vld), 0);
        drive(4'b0010, 1'b0);
        #1;
        check("R4", "penalty cycle", int'(slv_active), 0);
        cyc();
        check("R4", "granted after penalty", int'({gnt_vld, gnt_idx}), 5);
        check("R4", "active after penalty", int'(slv_active), 1);

        // R5 tie to lower index; R6 rotation
        drive('0, 1'b0);
        cfg_wr = 1'b1; cfg_park_lp = 1'b0; cfg_rr = 1'b0; cfg_prio = 8'b11_01_11_00;
        cyc();
        drive(4'b1010, 1'b1);
        cyc();
        check("R5", "tie to lower index", int'(gnt_idx), 1);
        drive('0, 1'b0);
        cfg_wr = 1'b1; cfg_rr = 1'b1;
        cyc();
        drive(4'b1011, 1'b1);
        cyc();
        check("R6", "after last=1 comes 3", int'(gnt_idx), 3);
        cyc();
        check("R6", "wrap to 0", int'(gnt_idx), 0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            mst_req   = N'($urandom_range(0, 15)) & N'($urandom_range(0, 15));
            mst_idle  = N'($urandom_range(0, 15));
            burst_end = ($urandom_range(0, 3) == 0);
            slv_ready = ($urandom_range(0, 1) == 1);
            cfg_wr    = ($urandom_range(0, 40) == 0);
            cfg_park_id = IW'($urandom_range(0, N - 1));
            cfg_park_lp = ($urandom_range(0, 2) == 0);
            cfg_rr      = ($urandom_range(0, 1) == 1);
            cfg_prio    = (N*PW)'($urandom);
            cyc();
        end

        summary();
        $finish;
    end

endmodule